// File: doc/BRIEF.md
# Comparator Event Trigger Controller

This block sits behind an analog comparator and turns its raw decision bit into clean digital signals. The raw bit arrives with no timing relation to the system clock, so it first passes through a flop synchronizer. The synchronized level is then gated by an enable and optionally inverted. The result is shown as a read-only status bit and, when software allows it, driven onto an output pin.

The block watches that adjusted level for a software-chosen kind of transition: none, rising, falling, or either. The first qualifying transition sets a sticky event flag and emits a one-cycle trigger pulse. The flag then blocks further triggers until software writes 0 to it.

Software reaches every field through one 16-bit word with a write strobe and a read-back bus.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `reg_rdata_o` reads 0 and `trig_o` and `pin_o` are low.
- R2: A change on `cmp_raw_i` reaches status bit 9 after exactly two rising clock edges. Bit 9 shows the adjusted level.
- R3: While the enable (bit 0) is 0, status bit 9 reads 0, `pin_o` stays low, and no event flag or trigger is produced.
- R4: With the invert field (bit 2) set to 1, the adjusted level is the complement of the synchronized raw bit. With it at 0, the adjusted level equals the raw bit.
- R5: `pin_o` equals the adjusted level when the pin-enable field (bit 1) is 1, and is 0 otherwise.
- R6: The edge field (bits 4:3) selects the transition of the adjusted level that counts: 0 never, 1 low-to-high, 2 high-to-low, 3 any change.
- R7: A qualifying transition sets event flag bit 8. While bit 8 is 1, further transitions produce no trigger and the flag stays 1.
- R8: Writing a word with bit 8 at 0 clears the flag, and writing bit 8 as 1 leaves it unchanged. If a clearing write and a qualifying transition land in the same cycle, the flag stays 1.
- R9: `trig_o` is high for exactly one cycle. That is the cycle in which bit 8 first reads 1.
- R10: A transition into the enabled state never counts as an edge, whatever the raw level is.
- R11: Bits 0, 1, 2 and 4:3 are read/write and bit 9 is read-only. Bits 5-7 and 10-15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Raw comparator decision, asynchronous |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read-back of control, flag and status |
| pin_o | output | 1 | Adjusted level driven to the external pin |
| trig_o | output | 1 | One-cycle event trigger / interrupt pulse |

## Verification
The assertions assume that the write strobe and write data are clean, synchronous values, that no word is written during reset, and that the raw input is held steady around each clock edge. They also assume that the invert field is changed only while the block is disabled, since an inversion made while enabled is itself a transition. The stimulus drives every input just after a falling clock edge. It reconfigures the edge field and the inversion only after a disabling write, and times the collision case by counting the two synchronizer edges plus the detection edge.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  typedef struct packed {
    logic      en;
    logic      pin_en;
    logic      inv;
    edge_sel_e sel;
  } cmp_ctrl_t;

  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned PIN_BIT  = 1;
  localparam int unsigned INV_BIT  = 2;
  localparam int unsigned SEL_LSB  = 3;
  localparam int unsigned EVT_BIT  = 8;
  localparam int unsigned STAT_BIT = 9;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_evt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  edge_sel_e sel_i,
  input  logic      lvl_i,
  output logic      hit_o
);
  logic prev_q;
  logic armed_q;  // enabled last cycle too; blocks a false edge on enable
  logic rise, fall, sel_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl_i;
      armed_q <= en_i;
    end
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: sel_hit = rise;
      EDGE_FALL: sel_hit = fall;
      EDGE_ANY:  sel_hit = rise | fall;
      default:   sel_hit = 1'b0;
    endcase
  end

  assign hit_o = en_i & armed_q & sel_hit;
endmodule

// File: rtl/cmp_ctrl_regs.sv
module cmp_ctrl_regs
  import cmp_evt_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             hit_i,
  input  logic             lvl_i,
  output cmp_ctrl_t        ctrl_o,
  output logic             trig_o,
  output logic [REG_W-1:0] rdata_o
);
  cmp_ctrl_t ctrl_q;
  logic      evt_q, trig_q, clr;

  assign clr = we_i & ~wdata_i[EVT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      evt_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      if (we_i) begin
        ctrl_q.en     <= wdata_i[EN_BIT];
        ctrl_q.pin_en <= wdata_i[PIN_BIT];
        ctrl_q.inv    <= wdata_i[INV_BIT];
        ctrl_q.sel    <= edge_sel_e'(wdata_i[SEL_LSB +: 2]);
      end
      // edge wins over a same-cycle clear
      evt_q  <= hit_i | (evt_q & ~clr);
      trig_q <= hit_i & ~evt_q;
    end
  end

  always_comb begin
    rdata_o                = '0;
    rdata_o[EN_BIT]        = ctrl_q.en;
    rdata_o[PIN_BIT]       = ctrl_q.pin_en;
    rdata_o[INV_BIT]       = ctrl_q.inv;
    rdata_o[SEL_LSB +: 2]  = ctrl_q.sel;
    rdata_o[EVT_BIT]       = evt_q;
    rdata_o[STAT_BIT]      = lvl_i;
  end

  assign ctrl_o = ctrl_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_W       = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_raw_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             pin_o,
  output logic             trig_o
);
  logic      raw_sync, lvl, hit;
  cmp_ctrl_t ctrl;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_raw_i),
    .q_o   (raw_sync)
  );

  assign lvl   = ctrl.en & (raw_sync ^ ctrl.inv);
  assign pin_o = ctrl.pin_en & lvl;

  cmp_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl.en),
    .sel_i (ctrl.sel),
    .lvl_i (lvl),
    .hit_o (hit)
  );

  cmp_ctrl_regs #(.REG_W(REG_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .wdata_i(reg_wdata_i),
    .hit_i  (hit),
    .lvl_i  (lvl),
    .ctrl_o (ctrl),
    .trig_o (trig_o),
    .rdata_o(reg_rdata_o)
  );
endmodule

// File: rtl/cmp_evt_ctrl_chk.sv
module cmp_evt_ctrl_chk #(
  parameter int unsigned REG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             pin_o,
  input logic             trig_o
);
  localparam logic [REG_W-1:0] USED = REG_W'(16'h031F);

  assert_trig_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  assert_trig_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> reg_rdata_o[8]);

  assert_trig_needs_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !$past(reg_rdata_o[8]));

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[8] && !(reg_we_i && !reg_wdata_i[8])) |=> reg_rdata_o[8]);

  assert_pin_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_o |-> (reg_rdata_o[1] && reg_rdata_o[9]));

  assert_disabled_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[0] |-> (!reg_rdata_o[9] && !pin_o));

  assert_disabled_no_trig_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reg_rdata_o[0]) |-> !trig_o);

  assert_unused_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~USED) == '0);
endmodule

bind cmp_evt_ctrl cmp_evt_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/cmp_evt_ctrl_tb.sv
module cmp_evt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pin, trig;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cmp_evt_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(raw), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_o(pin), .trig_o(trig)
  );

  // behavioural reference model
  logic s1, s2, m_en, m_oe, m_inv, m_evt, m_trig, m_prev, m_armed;
  logic [1:0] m_sel;

  function automatic logic m_lvl();
    return m_en ? (s2 ^ m_inv) : 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, m_en, m_oe, m_inv, m_evt, m_trig, m_prev, m_armed} = '0;
      m_sel = 2'd0;
    end else begin
      logic l, e;
      l = m_lvl();
      e = m_en && m_armed && (l != m_prev) &&
          ((m_sel == 2'd3) || (m_sel == 2'd1 && l) || (m_sel == 2'd2 && !l));
      m_trig  = e && !m_evt;
      m_evt   = e || (m_evt && !(we && !wdata[8]));
      m_prev  = l;
      m_armed = m_en;
      s2 = s1;
      s1 = raw;
      if (we) begin
        m_en = wdata[0]; m_oe = wdata[1]; m_inv = wdata[2]; m_sel = wdata[4:3];
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic l;
      l = m_lvl();
      check("R11 ctrl", {11'd0, rdata[4:0]}, {11'd0, m_sel, m_inv, m_oe, m_en});
      check("R4 status", {15'd0, rdata[9]}, {15'd0, l});
      check("R7 flag", {15'd0, rdata[8]}, {15'd0, m_evt});
      check("R9 trig", {15'd0, trig}, {15'd0, m_trig});
      check("R5 pin", {15'd0, pin}, {15'd0, m_oe & l});
      check("R11 unused", rdata & 16'hFCE0, 16'h0000);
    end
  end

  function automatic logic [15:0] cw(input logic en, input logic oe, input logic inv,
                                     input logic [1:0] sel, input logic keep);
    return {7'd0, keep, 3'd0, sel, inv, oe, en};
  endfunction

  task automatic wr(input logic [15:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cyc(3);
    check("R1 rdata in reset", rdata, 16'h0000);
    check("R1 trig/pin in reset", {14'd0, trig, pin}, 16'h0000);
    rst_n = 1'b1;
    cyc(2);
    check("R1 rdata after reset", rdata, 16'h0000);

    // rising edge, pin on; writing 1 to flag has no effect
    wr(cw(1, 1, 0, 2'd1, 1));
    cyc(3);
    check("R8 write1 no set", {15'd0, rdata[8]}, 16'h0000);
    raw = 1'b1;
    cyc(1);
    check("R2 one edge not yet", {15'd0, rdata[9]}, 16'h0000);
    cyc(1);
    check("R2 two edges seen", {15'd0, rdata[9]}, 16'h0001);
    check("R5 pin follows", {15'd0, pin}, 16'h0001);
    cyc(1);
    check("R6 rise fires trig", {15'd0, trig}, 16'h0001);
    check("R9 flag with trig", {15'd0, rdata[8]}, 16'h0001);
    cyc(1);
    check("R9 single pulse", {15'd0, trig}, 16'h0000);

    // sticky: more edges, no trigger
    raw = 1'b0; cyc(4); raw = 1'b1; cyc(4);
    check("R7 flag sticky", {15'd0, rdata[8]}, 16'h0001);

    wr(cw(1, 1, 0, 2'd1, 0));
    check("R8 cleared", {15'd0, rdata[8]}, 16'h0000);

    // falling select, pin disabled
    wr(cw(1, 0, 0, 2'd2, 1));
    check("R5 pin gated", {15'd0, pin}, 16'h0000);
    raw = 1'b0; cyc(3);
    check("R6 fall fires", {15'd0, rdata[8]}, 16'h0001);

    // inversion, configured while disabled; enabling with level 1 is no edge
    wr(cw(0, 0, 1, 2'd1, 0));
    wr(cw(1, 0, 1, 2'd1, 1));
    cyc(3);
    check("R10 no false edge", {15'd0, rdata[8]}, 16'h0000);
    check("R4 inverted level", {15'd0, rdata[9]}, 16'h0001);
    raw = 1'b1; cyc(4);
    check("R4 raw rise is adj fall", {15'd0, rdata[8]}, 16'h0000);
    raw = 1'b0; cyc(3);
    check("R4 raw fall is adj rise", {15'd0, rdata[8]}, 16'h0001);

    // any change
    wr(cw(0, 0, 0, 2'd3, 0));
    wr(cw(1, 0, 0, 2'd3, 1));
    raw = 1'b1; cyc(3);
    check("R6 any up", {15'd0, rdata[8]}, 16'h0001);
    wr(cw(1, 0, 0, 2'd3, 0));
    raw = 1'b0; cyc(3);
    check("R6 any down", {15'd0, rdata[8]}, 16'h0001);

    // collision: clear lands with a qualifying edge
    raw = 1'b1; cyc(2);
    we = 1'b1; wdata = cw(1, 0, 0, 2'd3, 0);
    @(negedge clk);
    we = 1'b0; wdata = '0;
    check("R8 edge wins clear", {15'd0, rdata[8]}, 16'h0001);
    check("R7 no trig while set", {15'd0, trig}, 16'h0000);
    wr(cw(1, 0, 0, 2'd3, 0));
    check("R8 clear alone", {15'd0, rdata[8]}, 16'h0000);

    // none select
    wr(cw(0, 1, 0, 2'd0, 0));
    wr(cw(1, 1, 0, 2'd0, 1));
    raw = 1'b0; cyc(4); raw = 1'b1; cyc(4); raw = 1'b0; cyc(4);
    check("R6 none never fires", {15'd0, rdata[8]}, 16'h0000);

    // disabled
    wr(cw(0, 1, 0, 2'd3, 1));
    raw = 1'b1; cyc(4);
    check("R3 status off", {15'd0, rdata[9]}, 16'h0000);
    check("R3 pin off", {15'd0, pin}, 16'h0000);
    raw = 1'b0; cyc(4);
    check("R3 no event", {14'd0, rdata[8], trig}, 16'h0000);

    // unused and read-only bits
    wr(16'hFEE0 | cw(0, 1, 1, 2'd2, 1));
    check("R11 layout", rdata, 16'h0016);

    cyc(2);
    summary();
  end
endmodule